// File: doc/BRIEF.md
# Vector Saturating Add/Subtract with Carry

This block is a lane-parallel signed arithmetic unit. Each lane takes two signed
elements and a one-bit carry (in add mode) or borrow (in subtract mode). It forms
the full three-operand result at a width where no overflow can occur. It then
limits that result once to the signed element range. The raw low bits of the
same result are also delivered, so that an accumulator's low slice can be loaded
in the same cycle as the limited result.

A caller presents both source vectors, the per-lane flag vector and the operation
select, all qualified by a valid strobe. One clock later the limited result and
the raw low slice appear on registered outputs, and a done strobe is raised for
that cycle. The carry or borrow is never limited on its own in an intermediate
step. Only the exact sum or difference is clamped, so a flag cannot be lost or
double counted at the range edges.

Top module: `vsat_addsub`

## Requirements
- R1: While reset is high and after it is released with no valid beat, `done` is 0 and `res_out` and `acc_lo_out` are all zeros.
- R2: With `op_sub` = 0, the exact value a + b + c is computed per lane, where a and b are signed 16-bit and c is 0 or 1. When that value is within [-32768, +32767], the lane result is its low 16 bits.
- R3: With `op_sub` = 1, the exact value a - b - c is computed per lane with no intermediate clamping. When that value is in range, the lane result is its low 16 bits.
- R4: An exact lane value below -32768 gives a lane result of 0x8000. This includes 0x8000 - 0 - 1.
- R5: An exact lane value above +32767 gives a lane result of 0x7FFF. This includes 0x7FFF + 0 + 1.
- R6: `acc_lo_out` carries the low 16 bits of every lane's exact value, unclamped. It is updated in the same cycle as `res_out`.
- R7: Outputs update on the rising edge at which `in_valid` is sampled high. `done` is high in exactly the cycles that follow a sampled valid beat, so back-to-back beats give back-to-back done cycles.
- R8: While `in_valid` is low, `res_out` and `acc_lo_out` keep their values.
- R9: Lane i occupies bits [16i+15:16i] of every vector port and uses bit i of `carry_in` only. Lanes do not affect each other.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Qualifies the operands for one cycle |
| op_sub | input | 1 | 0 selects add, 1 selects subtract |
| src_a | input | 128 | First source vector, eight signed 16-bit lanes |
| src_b | input | 128 | Second source vector, eight signed 16-bit lanes |
| carry_in | input | 8 | Per-lane carry or borrow bit |
| res_out | output | 128 | Saturated lane results |
| acc_lo_out | output | 128 | Unclamped low 16 bits of each exact lane value |
| done | output | 1 | One-cycle strobe per completed beat |

## Verification
The assertions assume that `in_valid`, `op_sub` and the operand buses are
driven to known levels whenever reset is low. They also assume that reset is
held for at least one rising edge before the first valid beat. The bench follows
these assumptions by driving every input to zero before reset is released. It
changes inputs only on falling edges and deasserts `in_valid` after each beat,
except in the test of consecutive beats. Operand patterns are chosen to hit both
clamp edges and the in-range band. The reference model works in 32-bit integers.

// File: rtl/vsat_pkg.sv
package vsat_pkg;

  typedef enum logic {
    OP_ADD = 1'b0,
    OP_SUB = 1'b1
  } vsat_op_e;

  localparam int unsigned VSAT_LANES_DEF = 8;
  localparam int unsigned VSAT_W_DEF     = 16;

endpackage

// File: rtl/vsat_lane_exact.sv
module vsat_lane_exact
  import vsat_pkg::*;
#(
  parameter int unsigned W  = 16,
  parameter int unsigned XW = W + 2
) (
  input  logic [W-1:0]          opa,
  input  logic [W-1:0]          opb,
  input  logic                  cflag,
  input  vsat_op_e              op,
  output logic signed [XW-1:0]  exact
);

  localparam int unsigned EXT = XW - W;

  logic signed [XW-1:0] a_x;
  logic signed [XW-1:0] b_x;
  logic signed [XW-1:0] c_x;

  always_comb begin
    a_x = {{EXT{opa[W-1]}}, opa};
    b_x = {{EXT{opb[W-1]}}, opb};
    c_x = {{(XW-1){1'b0}}, cflag};
    if (op == OP_SUB) begin
      exact = a_x - b_x - c_x;
    end else begin
      exact = a_x + b_x + c_x;
    end
  end

endmodule

// File: rtl/vsat_clamp.sv
module vsat_clamp #(
  parameter int unsigned W  = 16,
  parameter int unsigned XW = W + 2
) (
  input  logic signed [XW-1:0] exact,
  output logic [W-1:0]         sat,
  output logic [W-1:0]         wrap
);

  localparam logic signed [XW-1:0] LIM_HI = {{(XW-W+1){1'b0}}, {(W-1){1'b1}}};
  localparam logic signed [XW-1:0] LIM_LO = {{(XW-W+1){1'b1}}, {(W-1){1'b0}}};
  localparam logic [W-1:0]         OUT_HI = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0]         OUT_LO = {1'b1, {(W-1){1'b0}}};

  always_comb begin
    wrap = exact[W-1:0];
    if (exact > LIM_HI) begin
      sat = OUT_HI;
    end else if (exact < LIM_LO) begin
      sat = OUT_LO;
    end else begin
      sat = exact[W-1:0];
    end
  end

endmodule

// File: rtl/vsat_addsub.sv
module vsat_addsub
  import vsat_pkg::*;
#(
  parameter int unsigned LANES = VSAT_LANES_DEF,
  parameter int unsigned W     = VSAT_W_DEF
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               in_valid,
  input  logic               op_sub,
  input  logic [LANES*W-1:0] src_a,
  input  logic [LANES*W-1:0] src_b,
  input  logic [LANES-1:0]   carry_in,
  output logic [LANES*W-1:0] res_out,
  output logic [LANES*W-1:0] acc_lo_out,
  output logic               done
);

  localparam int unsigned XW = W + 2;
  localparam int unsigned VW = LANES * W;
  localparam logic [W-1:0] SAT_POS = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0] SAT_NEG = {1'b1, {(W-1){1'b0}}};

  vsat_op_e        op_sel;
  logic [VW-1:0]   res_d;
  logic [VW-1:0]   acc_d;
  logic [VW-1:0]   res_q;
  logic [VW-1:0]   acc_q;
  logic            done_q;

  assign op_sel = op_sub ? OP_SUB : OP_ADD;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic signed [XW-1:0] lane_exact;

    vsat_lane_exact #(.W(W), .XW(XW)) u_exact (
      .opa   (src_a[g*W +: W]),
      .opb   (src_b[g*W +: W]),
      .cflag (carry_in[g]),
      .op    (op_sel),
      .exact (lane_exact)
    );

    vsat_clamp #(.W(W), .XW(XW)) u_clamp (
      .exact (lane_exact),
      .sat   (res_d[g*W +: W]),
      .wrap  (acc_d[g*W +: W])
    );

    // R4 R5 R6: a registered lane differs from its raw slice only at a limit
    a_r5_sat_or_raw: assert property (@(posedge clk) disable iff (rst)
      done |-> (res_q[g*W +: W] == acc_q[g*W +: W]) ||
               (res_q[g*W +: W] == SAT_POS) || (res_q[g*W +: W] == SAT_NEG));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      res_q  <= '0;
      acc_q  <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= in_valid;
      if (in_valid) begin
        res_q <= res_d;
        acc_q <= acc_d;
      end
    end
  end

  assign res_out    = res_q;
  assign acc_lo_out = acc_q;
  assign done       = done_q;

  // R1: reset clears the strobe
  a_r1_reset_quiet: assert property (@(posedge clk) rst |=> !done);

  // R7: every sampled beat yields a strobe in the next cycle
  a_r7_done_follows: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> done);

  // R7: no strobe without a beat
  a_r7_no_spurious: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !done);

  // R8: outputs hold while idle
  a_r8_hold: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> ($stable(res_out) && $stable(acc_lo_out)));

endmodule

// File: tb/test_vsat_addsub.sv
module test_vsat_addsub;

  localparam int LANES = 8;
  localparam int W     = 16;

  logic               clk = 1'b0;
  logic               rst;
  logic               in_valid;
  logic               op_sub;
  logic [LANES*W-1:0] src_a;
  logic [LANES*W-1:0] src_b;
  logic [LANES-1:0]   carry_in;
  logic [LANES*W-1:0] res_out;
  logic [LANES*W-1:0] acc_lo_out;
  logic               done;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  vsat_addsub #(.LANES(LANES), .W(W)) i_vsat_addsub (
    .clk(clk), .rst(rst), .in_valid(in_valid), .op_sub(op_sub),
    .src_a(src_a), .src_b(src_b), .carry_in(carry_in),
    .res_out(res_out), .acc_lo_out(acc_lo_out), .done(done)
  );

  function automatic int exact_of(logic [15:0] a, logic [15:0] b, logic c, logic sub);
    int ia, ib, ic;
    ia = int'($signed(a));
    ib = int'($signed(b));
    ic = c ? 1 : 0;
    return sub ? (ia - ib - ic) : (ia + ib + ic);
  endfunction

  function automatic logic [15:0] clamp_of(int e);
    if (e > 32767) return 16'h7FFF;
    if (e < -32768) return 16'h8000;
    return e[15:0];
  endfunction

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // Check outputs against operands of the last beat (called at a falling edge)
  task automatic check_lanes(string tag, logic [LANES*W-1:0] a, logic [LANES*W-1:0] b,
                             logic [LANES-1:0] c, logic sub);
    for (int i = 0; i < LANES; i++) begin
      int e;
      e = exact_of(a[i*W +: W], b[i*W +: W], c[i], sub);
      chk(tag, $sformatf("lane%0d result", i), {16'h0, res_out[i*W +: W]}, {16'h0, clamp_of(e)});
      chk("R6", $sformatf("lane%0d acc_lo", i), {16'h0, acc_lo_out[i*W +: W]}, {16'h0, e[15:0]});
    end
  endtask

  task automatic beat(string tag, logic [LANES*W-1:0] a, logic [LANES*W-1:0] b,
                      logic [LANES-1:0] c, logic sub);
    @(negedge clk);
    src_a = a; src_b = b; carry_in = c; op_sub = sub; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk("R7", "done after beat", {31'h0, done}, 32'h1);
    check_lanes(tag, a, b, c, sub);
  endtask

  function automatic logic [LANES*W-1:0] fill(logic [15:0] v);
    logic [LANES*W-1:0] r;
    for (int i = 0; i < LANES; i++) r[i*W +: W] = v;
    return r;
  endfunction

  function automatic logic [LANES*W-1:0] rnd_vec(int span);
    logic [LANES*W-1:0] r;
    for (int i = 0; i < LANES; i++) begin
      int v;
      v = int'($urandom_range(2*span, 0)) - span;
      r[i*W +: W] = v[15:0];
    end
    return r;
  endfunction

  task automatic t_reset;
    rst = 1'b1; in_valid = 1'b0; op_sub = 1'b0;
    src_a = '0; src_b = '0; carry_in = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1", "done after reset", {31'h0, done}, 32'h0);
    chk("R1", "res_out zero", {31'h0, |res_out}, 32'h0);
    chk("R1", "acc_lo_out zero", {31'h0, |acc_lo_out}, 32'h0);
  endtask

  task automatic t_add_range;
    // R2: small operands in range, mixed carries
    for (int k = 0; k < 6; k++)
      beat("R2", rnd_vec(12000), rnd_vec(12000), LANES'($urandom), 1'b0);
    beat("R2", fill(16'hFFFF), fill(16'h0001), 8'hA5, 1'b0);
  endtask

  task automatic t_sub_range;
    // R3: in-range differences, borrows across lanes
    for (int k = 0; k < 6; k++)
      beat("R3", rnd_vec(12000), rnd_vec(12000), LANES'($urandom), 1'b1);
    beat("R3", fill(16'h0000), fill(16'h0000), 8'hFF, 1'b1);
  endtask

  task automatic t_overflow;
    // R5: 0x7FFF + 0 + 1 must clamp, 0x7FFF + 0 + 0 stays
    beat("R5", fill(16'h7FFF), fill(16'h0000), 8'h0F, 1'b0);
    beat("R5", fill(16'h7FFF), fill(16'h7FFF), 8'hFF, 1'b0);
    beat("R5", fill(16'h7FFE), fill(16'h8000), 8'h33, 1'b1);
    for (int k = 0; k < 4; k++)
      beat("R5", rnd_vec(32767), rnd_vec(32767), LANES'($urandom), 1'b0);
  endtask

  task automatic t_underflow;
    // R4: 0x8000 - 0 - 1 must clamp, 0x8000 - 0 - 0 stays
    beat("R4", fill(16'h8000), fill(16'h0000), 8'hF0, 1'b1);
    beat("R4", fill(16'h8000), fill(16'h7FFF), 8'hFF, 1'b1);
    beat("R4", fill(16'h8000), fill(16'h8000), 8'hC3, 1'b0);
    beat("R4", fill(16'h8000), fill(16'hFFFF), 8'h00, 1'b0);
    for (int k = 0; k < 4; k++)
      beat("R4", rnd_vec(32768), rnd_vec(32767), LANES'($urandom), 1'b1);
  endtask

  task automatic t_lane_isolation;
    // R9: a single carry bit affects only its own lane
    for (int i = 0; i < LANES; i++) begin
      logic [LANES*W-1:0] a;
      a = '0;
      a[i*W +: W] = 16'h7FFF;
      beat("R9", a, '0, LANES'(1) << i, 1'b0);
    end
  endtask

  task automatic t_hold;
    logic [LANES*W-1:0] r0, a0;
    beat("R8", fill(16'h1234), fill(16'h0101), 8'h55, 1'b0);
    r0 = res_out; a0 = acc_lo_out;
    @(negedge clk);
    src_a = fill(16'h7FFF); src_b = fill(16'h7FFF); carry_in = '1; op_sub = 1'b1;
    repeat (3) @(negedge clk);
    chk("R8", "res_out held", {31'h0, res_out == r0}, 32'h1);
    chk("R8", "acc_lo_out held", {31'h0, acc_lo_out == a0}, 32'h1);
    chk("R7", "done low when idle", {31'h0, done}, 32'h0);
  endtask

  task automatic t_back_to_back;
    logic [LANES*W-1:0] a1, b1, a2, b2;
    a1 = rnd_vec(32767); b1 = rnd_vec(32767);
    a2 = rnd_vec(32767); b2 = rnd_vec(32767);
    @(negedge clk);
    src_a = a1; src_b = b1; carry_in = 8'h3C; op_sub = 1'b0; in_valid = 1'b1;
    @(negedge clk);
    chk("R7", "done first beat", {31'h0, done}, 32'h1);
    check_lanes("R7", a1, b1, 8'h3C, 1'b0);
    src_a = a2; src_b = b2; carry_in = 8'hC3; op_sub = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk("R7", "done second beat", {31'h0, done}, 32'h1);
    check_lanes("R7", a2, b2, 8'hC3, 1'b1);
    @(negedge clk);
    chk("R7", "done drops", {31'h0, done}, 32'h0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL R7 watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_add_range();
    t_sub_range();
    t_overflow();
    t_underflow();
    t_lane_isolation();
    t_hold();
    t_back_to_back();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule